// File: doc/BRIEF.md
# Split-Byte General Register File

This block stores the working registers of a 16-bit datapath. It holds eight 16-bit registers. The first four are general data registers. Each of them can be reached as a whole word or as two independent byte halves. The last four are offset registers: a stack pointer, a frame (base) pointer, a source index and a destination index. They are reached only as whole words. Arithmetic, flag generation and address formation sit outside the block.

There are two read ports and one write port. Each port carries a 3-bit register code and a width bit that selects byte or word access. The read ports are purely combinational. The write port commits on the rising clock edge. A byte write is merged into its half of the target register, and the other half keeps its value. A byte read places the selected half on bits 7:0 of the port and drives bits 15:8 to zero.

Top module: `gprf_top`

## Requirements
- R1: While the active-low reset is asserted, every register is cleared to 0x0000, so every read after reset returns zero.
- R2: A word write (wide = 1) with code 0 to 7 stores all 16 bits of `wr_data` into register 0 to 7. The word order is: data registers 0, 1, 2, 3, then stack pointer (4), frame pointer (5), source index (6) and destination index (7). A word read with the same code returns the full value.
- R3: A byte read with code 0 to 3 returns bits 7:0 of data register 0 to 3 on port bits 7:0, with port bits 15:8 equal to zero.
- R4: A byte read with code 4 to 7 returns bits 15:8 of data register 0 to 3 (code minus 4) on port bits 7:0, with port bits 15:8 equal to zero.
- R5: A byte write with code 0 to 3 loads `wr_data[7:0]` into bits 7:0 of data register 0 to 3. Bits 15:8 of that register and `wr_data[15:8]` play no part.
- R6: A byte write with code 4 to 7 loads `wr_data[7:0]` into bits 15:8 of data register 0 to 3 (code minus 4). Bits 7:0 of that register are left unchanged.
- R7: A read of a register in the same cycle it is written returns the value held before the write. The written value appears from the next cycle on.
- R8: With `wr_en` low, no register changes, whatever the other write inputs carry.
- R9: The two read ports are independent. Each can select any register at either width in the same cycle.
- R10: A byte write never alters the offset registers (word codes 4 to 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_wide | input | 1 | Read port A width: 1 = word, 0 = byte |
| rd_a_sel | input | 3 | Read port A register code |
| rd_a_data | output | 16 | Read port A data (byte reads zero-extended) |
| rd_b_wide | input | 1 | Read port B width: 1 = word, 0 = byte |
| rd_b_sel | input | 3 | Read port B register code |
| rd_b_data | output | 16 | Read port B data (byte reads zero-extended) |
| wr_en | input | 1 | Write enable |
| wr_wide | input | 1 | Write width: 1 = word, 0 = byte |
| wr_sel | input | 3 | Write register code |
| wr_data | input | 16 | Write data; a byte write uses bits 7:0 |

## Verification
The checker watches the per-lane write enables and the stored register array on every cycle. On each cycle it confirms the following:
- At most one lane is written per edge.
- A high-half byte write touches only bits 15:8, and a low-half byte write touches only bits 7:0.
- Offset registers never take a byte write.
- Idle cycles leave the whole array still.
- Byte reads come out zero-extended.

The directed scenarios are needed for the rest: the mapping of each code to a visible register and half, the old-value-then-new-value timing of a same-cycle read and write, and two ports reading different registers at different widths at once. These are checked against a bench model of the eight registers.

// File: rtl/gprf_pkg.sv
package gprf_pkg;

  localparam int WORD_W    = 16;
  localparam int BYTE_W    = WORD_W / 2;
  localparam int NUM_REGS  = 8;
  localparam int NUM_SPLIT = 4;
  localparam int SEL_W     = $clog2(NUM_REGS);
  localparam int SPLIT_W   = $clog2(NUM_SPLIT);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [SEL_W-1:0]  sel_t;

  typedef enum logic [SEL_W-1:0] {
    CODE_D0  = 3'd0,
    CODE_D1  = 3'd1,
    CODE_D2  = 3'd2,
    CODE_D3  = 3'd3,
    CODE_STK = 3'd4,
    CODE_FRM = 3'd5,
    CODE_SRC = 3'd6,
    CODE_DST = 3'd7
  } word_code_e;

  // byte codes: upper code bit picks the high half
  function automatic logic byte_is_high(sel_t sel);
    return sel[SEL_W-1];
  endfunction

  // register that owns a byte code
  function automatic sel_t byte_owner(sel_t sel);
    return sel_t'(sel[SPLIT_W-1:0]);
  endfunction

  function automatic byte_t pick_half(word_t w, logic hi);
    return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  function automatic word_t zext_byte(byte_t b);
    return word_t'(b);
  endfunction

  // byte presented to a high lane: upper word bits or the byte operand
  function automatic byte_t high_lane_src(word_t d, logic wide);
    return wide ? d[WORD_W-1:BYTE_W] : d[BYTE_W-1:0];
  endfunction

endpackage

// File: rtl/gprf_wr_decode.sv
module gprf_wr_decode
  import gprf_pkg::*;
#(
  parameter int NREGS  = NUM_REGS,
  parameter int NSPLIT = NUM_SPLIT
) (
  input  logic             wr_en,
  input  logic             wr_wide,
  input  sel_t             wr_sel,
  input  word_t            wr_data,
  output logic [NREGS-1:0] lo_en,
  output logic [NREGS-1:0] hi_en,
  output byte_t            lo_byte,
  output byte_t            hi_byte
);

  logic hit_hi;
  sel_t owner;

  always_comb begin
    hit_hi = byte_is_high(wr_sel);
    owner  = byte_owner(wr_sel);
    lo_en  = '0;
    hi_en  = '0;
    for (int r = 0; r < NREGS; r++) begin
      if (wr_en) begin
        if (wr_wide) begin
          if (wr_sel == sel_t'(r)) begin
            lo_en[r] = 1'b1;
            hi_en[r] = 1'b1;
          end
        end else if (r < NSPLIT && owner == sel_t'(r)) begin
          lo_en[r] = ~hit_hi;
          hi_en[r] = hit_hi;
        end
      end
    end
  end

  assign lo_byte = wr_data[BYTE_W-1:0];
  assign hi_byte = high_lane_src(wr_data, wr_wide);

endmodule

// File: rtl/gprf_storage.sv
module gprf_storage
  import gprf_pkg::*;
#(
  parameter int NREGS = NUM_REGS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREGS-1:0] lo_en,
  input  logic [NREGS-1:0] hi_en,
  input  byte_t            lo_byte,
  input  byte_t            hi_byte,
  output word_t            regs_q [NREGS]
);

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    byte_t lo_q, hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lo_q <= '0;
      else if (lo_en[r]) lo_q <= lo_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hi_q <= '0;
      else if (hi_en[r]) hi_q <= hi_byte;
    end

    assign regs_q[r] = {hi_q, lo_q};
  end

endmodule

// File: rtl/gprf_rd_port.sv
module gprf_rd_port
  import gprf_pkg::*;
#(
  parameter int NREGS = NUM_REGS
) (
  input  word_t regs_q [NREGS],
  input  logic  rd_wide,
  input  sel_t  rd_sel,
  output word_t rd_data
);

  word_t whole;
  word_t owner_w;

  always_comb begin
    whole   = regs_q[rd_sel];
    owner_w = regs_q[byte_owner(rd_sel)];
    rd_data = rd_wide ? whole
                      : zext_byte(pick_half(owner_w, byte_is_high(rd_sel)));
  end

endmodule

// File: rtl/gprf_top.sv
module gprf_top
  import gprf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_a_wide,
  input  logic [2:0]  rd_a_sel,
  output logic [15:0] rd_a_data,
  input  logic        rd_b_wide,
  input  logic [2:0]  rd_b_sel,
  output logic [15:0] rd_b_data,
  input  logic        wr_en,
  input  logic        wr_wide,
  input  logic [2:0]  wr_sel,
  input  logic [15:0] wr_data
);

  // named internal events for the checker
  logic [NUM_REGS-1:0] lane_lo_we;
  logic [NUM_REGS-1:0] lane_hi_we;
  byte_t               lane_lo_byte;
  byte_t               lane_hi_byte;
  word_t               reg_view [NUM_REGS];

  gprf_wr_decode #(.NREGS(NUM_REGS), .NSPLIT(NUM_SPLIT)) wdec_i (
    .wr_en   (wr_en),
    .wr_wide (wr_wide),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .lo_en   (lane_lo_we),
    .hi_en   (lane_hi_we),
    .lo_byte (lane_lo_byte),
    .hi_byte (lane_hi_byte)
  );

  gprf_storage #(.NREGS(NUM_REGS)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .lo_en   (lane_lo_we),
    .hi_en   (lane_hi_we),
    .lo_byte (lane_lo_byte),
    .hi_byte (lane_hi_byte),
    .regs_q  (reg_view)
  );

  gprf_rd_port #(.NREGS(NUM_REGS)) rpa_i (
    .regs_q  (reg_view),
    .rd_wide (rd_a_wide),
    .rd_sel  (rd_a_sel),
    .rd_data (rd_a_data)
  );

  gprf_rd_port #(.NREGS(NUM_REGS)) rpb_i (
    .regs_q  (reg_view),
    .rd_wide (rd_b_wide),
    .rd_sel  (rd_b_sel),
    .rd_data (rd_b_data)
  );

endmodule

// File: rtl/gprf_checker.sv
module gprf_checker
  import gprf_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        rd_a_wide,
  input logic [15:0] rd_a_data,
  input logic        rd_b_wide,
  input logic [15:0] rd_b_data,
  input logic        wr_en,
  input logic        wr_wide,
  input logic [2:0]  wr_sel,
  input logic [15:0] wr_data,
  input logic [7:0]  lane_lo_we,
  input logic [7:0]  lane_hi_we,
  input word_t       reg_view [NUM_REGS]
);

  logic [NUM_REGS*WORD_W-1:0] flat_view;
  always_comb
    for (int r = 0; r < NUM_REGS; r++)
      flat_view[r*WORD_W +: WORD_W] = reg_view[r];

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (flat_view == '0));

  assert_word_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_wide) |=> (reg_view[$past(wr_sel)] == $past(wr_data)));

  assert_zext_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_a_wide |-> (rd_a_data[15:8] == 8'h00));

  assert_zext_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_b_wide |-> (rd_b_data[15:8] == 8'h00));

  assert_low_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_wide && !wr_sel[2]) |=>
      (reg_view[$past(wr_sel)][15:8] == $past(reg_view[wr_sel][15:8])) &&
      (reg_view[$past(wr_sel)][7:0]  == $past(wr_data[7:0])));

  assert_high_merge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_wide && wr_sel[2]) |->
      (lane_lo_we == '0) && ($countones(lane_hi_we) == 1));

  assert_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_lo_we) && $onehot0(lane_hi_we));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(flat_view));

  assert_no_ptr_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_wide) |=> $stable(flat_view[NUM_REGS*WORD_W-1:NUM_SPLIT*WORD_W]));

endmodule

bind gprf_top gprf_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_a_wide  (rd_a_wide),
  .rd_a_data  (rd_a_data),
  .rd_b_wide  (rd_b_wide),
  .rd_b_data  (rd_b_data),
  .wr_en      (wr_en),
  .wr_wide    (wr_wide),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .lane_lo_we (lane_lo_we),
  .lane_hi_we (lane_hi_we),
  .reg_view   (reg_view)
);

// File: tb/gprf_top_tb_top.sv
`timescale 1ns/1ps
module gprf_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_a_wide = 1'b1, rd_b_wide = 1'b1;
  logic [2:0]  rd_a_sel = '0, rd_b_sel = '0;
  logic [15:0] rd_a_data, rd_b_data;
  logic        wr_en = 1'b0, wr_wide = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model [8];

  always #2 clk = ~clk;

  gprf_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_wide(rd_a_wide), .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_wide(rd_b_wide), .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel), .wr_data(wr_data)
  );

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // bench view of a byte read: low codes pick bits 7:0, high codes bits 15:8
  function automatic logic [15:0] byte_view(logic [2:0] code);
    logic [15:0] w = model[{1'b0, code[1:0]}];
    return code[2] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  task automatic write(logic wide, logic [2:0] sel, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_wide = wide; wr_sel = sel; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (wide) model[sel] = d;
    else if (sel[2]) model[{1'b0, sel[1:0]}][15:8] = d[7:0];
    else model[{1'b0, sel[1:0]}][7:0] = d[7:0];
  endtask

  task automatic read_a(logic wide, logic [2:0] sel, output logic [15:0] v);
    @(negedge clk);
    rd_a_wide = wide; rd_a_sel = sel;
    #1 v = rd_a_data;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int r = 0; r < 8; r++) begin
      read_a(1'b1, 3'(r), v);
      check("R1 reset word", v, 16'h0000);
    end
  endtask

  task automatic t_word_all();
    logic [15:0] v;
    for (int r = 0; r < 8; r++) write(1'b1, 3'(r), 16'h1100 * 16'(r + 1) + 16'h0013 * 16'(r));
    for (int r = 0; r < 8; r++) begin
      read_a(1'b1, 3'(r), v);
      check("R2 word code", v, model[r]);
    end
  endtask

  task automatic t_byte_read();
    logic [15:0] v;
    for (int c = 0; c < 4; c++) begin
      read_a(1'b0, 3'(c), v);
      check("R3 low byte read", v, byte_view(3'(c)));
    end
    for (int c = 4; c < 8; c++) begin
      read_a(1'b0, 3'(c), v);
      check("R4 high byte read", v, byte_view(3'(c)));
    end
  endtask

  task automatic t_byte_low();
    logic [15:0] v;
    write(1'b1, 3'd2, 16'hA5C3);
    write(1'b0, 3'd2, 16'hFF3C);
    read_a(1'b1, 3'd2, v);
    check("R5 low byte write merge", v, 16'hA53C);
    write(1'b0, 3'd0, 16'h7E01);
    read_a(1'b1, 3'd0, v);
    check("R5 low byte write reg0", v, model[0]);
  endtask

  task automatic t_byte_high();
    logic [15:0] v;
    write(1'b1, 3'd3, 16'h1234);
    write(1'b0, 3'd7, 16'h99EE);
    read_a(1'b1, 3'd3, v);
    check("R6 high byte write merge", v, 16'hEE34);
    write(1'b0, 3'd5, 16'h0042);
    read_a(1'b1, 3'd1, v);
    check("R6 high byte write reg1", v, model[1]);
    read_a(1'b0, 3'd5, v);
    check("R6 high byte readback", v, 16'h0042);
  endtask

  task automatic t_no_ptr();
    logic [15:0] v;
    for (int c = 0; c < 8; c++) write(1'b0, 3'(c), 16'h00D0 + 16'(c));
    for (int r = 4; r < 8; r++) begin
      read_a(1'b1, 3'(r), v);
      check("R10 offset reg untouched by byte write", v, model[r]);
    end
  endtask

  task automatic t_same_cycle();
    logic [15:0] old_v, v;
    old_v = model[6];
    @(negedge clk);
    rd_a_wide = 1'b1; rd_a_sel = 3'd6;
    wr_en = 1'b1; wr_wide = 1'b1; wr_sel = 3'd6; wr_data = 16'hBEEF;
    #1 v = rd_a_data;
    check("R7 same-cycle read old value", v, old_v);
    @(posedge clk); #1;
    wr_en = 1'b0; model[6] = 16'hBEEF;
    v = rd_a_data;
    check("R7 new value next cycle", v, 16'hBEEF);
  endtask

  task automatic t_idle();
    logic [15:0] v;
    @(negedge clk);
    wr_en = 1'b0; wr_wide = 1'b1; wr_sel = 3'd1; wr_data = 16'hDEAD;
    @(posedge clk); #1;
    read_a(1'b1, 3'd1, v);
    check("R8 disabled write ignored", v, model[1]);
  endtask

  task automatic t_dual();
    @(negedge clk);
    rd_a_wide = 1'b1; rd_a_sel = 3'd4;
    rd_b_wide = 1'b0; rd_b_sel = 3'd7;
    #1;
    check("R9 port A word", rd_a_data, model[4]);
    check("R9 port B high byte", rd_b_data, byte_view(3'd7));
    @(negedge clk);
    rd_a_wide = 1'b0; rd_a_sel = 3'd0;
    rd_b_wide = 1'b1; rd_b_sel = 3'd3;
    #1;
    check("R9 port A low byte", rd_a_data, byte_view(3'd0));
    check("R9 port B word", rd_b_data, model[3]);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int r = 0; r < 8; r++) model[r] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_word_all();
    t_byte_read();
    t_byte_low();
    t_byte_high();
    t_no_ptr();
    t_same_cycle();
    t_idle();
    t_dual();
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule